// File: doc/BRIEF.md
# Delayed One-Shot / Continuous Pulse Timer

A down-counting timer that drives a toggling output level. Software loads a start count and a reload count through a small register write port. It then starts the timer by setting an enable bit, or lets a one-cycle start pulse from a neighbouring timer do it. After starting, the counter steps down by one on every cycle in which the count-tick qualifier is high. An underflow occurs when the counter sits at zero on a tick.

In one-shot mode, the first underflow flips the output and loads the reload count. The second underflow flips the output back and halts the timer, so a single pulse appears after a programmable delay. In continuous mode, the output flips once when the timer starts and again on every underflow, and each underflow reloads the counter. The result is a pulse train that runs until software clears the enable bit. Each underflow can raise a one-cycle interrupt request.

Top module: `pulse_timer`

## Requirements
- R1: After synchronous reset, the pulse output, interrupt request and running flag are 0, and the count is 0.
- R2: A write to address 0 sets the count, which is visible on `count_o` in the next cycle. A write to address 1 sets the reload count. Address 2 is control: bit 0 enable, bit 1 mode (0 one-shot, 1 continuous), bit 2 interrupt enable, bit 3 output preset level.
- R3: A stopped timer starts on a control write with bit 0 set, or on an `ext_start` pulse. While running, the count drops by one only in cycles where `count_tick` is high. A stopped timer ignores ticks.
- R4: In one-shot mode with start count C, the first underflow comes on the (C+1)-th tick after start. It flips `pulse_o` and loads the reload count.
- R5: In one-shot mode with reload count R, the second underflow comes R+1 ticks after the first. It flips `pulse_o`, clears `running_o` and leaves the count at 0, where it stays despite further ticks.
- R6: In continuous mode, `pulse_o` flips in the same cycle that the timer starts.
- R7: In continuous mode, every underflow reloads the counter and flips `pulse_o`, and the timer keeps running.
- R8: A control write with bit 0 clear stops the timer in the next cycle. Once stopped, the count holds and no further flips or interrupts occur.
- R9: With interrupt enable set, `irq_o` is high for the cycle after each underflow, in both modes. With interrupt enable clear, it stays 0.
- R10: A control write with bit 0 clear sets `pulse_o` to the bit 3 level.
- R11: While the timer runs, an `ext_start` pulse or a control write with bit 0 set leaves the count sequence and output timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 reload, 2 control |
| wr_data | input | 16 | Write data |
| count_tick | input | 1 | Count qualifier, one step per high cycle |
| ext_start | input | 1 | Start pulse from a companion timer |
| pulse_o | output | 1 | Toggle output level |
| irq_o | output | 1 | One-cycle interrupt request |
| running_o | output | 1 | Enable state, self-cleared at one-shot end |
| count_o | output | 16 | Current counter value |

## Verification
On every cycle, the assertions check the following:
- Each running tick lowers the count by exactly one, and the count holds without a tick or load.
- `pulse_o` changes only after an underflow, a control write or a start pulse.
- The running flag falls only after a stop write or a one-shot final underflow.
- An interrupt follows only a running tick taken at zero.

Only the bench scenarios show the exact delay and width in cycles for chosen start and reload values, in both modes and with gated ticks. They also show that a start request on a running timer is ignored, that the level is preset correctly, and that the one-shot counter comes to rest at zero.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CTRL   = 2'd2
  } reg_sel_e;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_CONT    = 1'b1
  } mode_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_MODE = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_LVL  = 3;
endpackage

// File: rtl/pt_regs.sv
module pt_regs
  import pt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  reload_q,
  output mode_e             mode_q,
  output logic              ie_q,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              ctl_wr,
  output logic              ctl_en,
  output mode_e             ctl_mode,
  output logic              ctl_lvl
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(REG_RELOAD);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);

  // decoded strobes, combinational
  always_comb begin
    cnt_ld   = wr_en && (wr_addr == A_COUNT);
    ctl_wr   = wr_en && (wr_addr == A_CTRL);
    cnt_val  = wr_data;
    ctl_en   = wr_data[CTL_EN];
    ctl_mode = mode_e'(wr_data[CTL_MODE]);
    ctl_lvl  = wr_data[CTL_LVL];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      mode_q   <= MODE_ONESHOT;
      ie_q     <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_RELOAD) reload_q <= wr_data;
      if (wr_addr == A_CTRL) begin
        mode_q <= mode_e'(wr_data[CTL_MODE]);
        ie_q   <= wr_data[CTL_IE];
      end
    end
  end
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             last_uf,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf
);
  logic at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    uf      = step && at_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      if (at_zero) cnt_q <= last_uf ? cnt_q : reload_val;
      else         cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R3: a running tick on a nonzero count lowers it by one
  a_r3_step_dec: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R3: no tick and no load leaves the count alone
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/pt_seq.sv
module pt_seq
  import pt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ctl_wr,
  input  logic  ctl_en,
  input  mode_e ctl_mode,
  input  logic  ctl_lvl,
  input  logic  ext_trig,
  input  mode_e mode_q,
  input  logic  ie_q,
  input  logic  tick,
  input  logic  uf,
  output logic  step,
  output logic  last_uf,
  output logic  run_q,
  output logic  phase_q,
  output logic  out_q,
  output logic  irq_q
);
  logic  stop_sw;
  logic  start;
  mode_e mode_eff;

  always_comb begin
    stop_sw  = ctl_wr && !ctl_en;
    start    = !run_q && !stop_sw && ((ctl_wr && ctl_en) || ext_trig);
    mode_eff = ctl_wr ? ctl_mode : mode_q;
    step     = run_q && tick && !stop_sw;
    last_uf  = (mode_q == MODE_ONESHOT) && phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= uf && ie_q;
      if (stop_sw) begin
        run_q <= 1'b0;
        out_q <= ctl_lvl;
      end else if (start) begin
        run_q   <= 1'b1;
        phase_q <= 1'b0;
        if (mode_eff == MODE_CONT) out_q <= ~out_q;
      end else if (uf) begin
        out_q   <= ~out_q;
        phase_q <= 1'b1;
        if (last_uf) run_q <= 1'b0;
      end
    end
  end

  // R7: continuous underflow never halts the timer
  a_r7_cont_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (uf && mode_q == MODE_CONT && !stop_sw) |=> run_q);

  // R11: a start pulse on a running timer leaves its phase alone
  a_r11_trig_ignored: assert property (@(posedge clk) disable iff (rst)
    (run_q && ext_trig && !uf && !ctl_wr) |=> (run_q && $stable(phase_q)));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              count_tick,
  input  logic              ext_start,
  output logic              pulse_o,
  output logic              irq_o,
  output logic              running_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] reload_w, cnt_val_w;
  mode_e            mode_q_w, ctl_mode_w;
  logic             ie_w, cnt_ld_w, ctl_wr_w, ctl_en_w, ctl_lvl_w;
  logic             step_w, uf_w, last_w, phase_w;

  pt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_q(reload_w), .mode_q(mode_q_w), .ie_q(ie_w),
    .cnt_ld(cnt_ld_w), .cnt_val(cnt_val_w),
    .ctl_wr(ctl_wr_w), .ctl_en(ctl_en_w), .ctl_mode(ctl_mode_w), .ctl_lvl(ctl_lvl_w)
  );

  pt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_ld_w), .load_val(cnt_val_w),
    .step(step_w), .reload_val(reload_w), .last_uf(last_w),
    .cnt_q(count_o), .uf(uf_w)
  );

  pt_seq u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr_w), .ctl_en(ctl_en_w),
    .ctl_mode(ctl_mode_w), .ctl_lvl(ctl_lvl_w), .ext_trig(ext_start),
    .mode_q(mode_q_w), .ie_q(ie_w), .tick(count_tick), .uf(uf_w),
    .step(step_w), .last_uf(last_w), .run_q(running_o), .phase_q(phase_w),
    .out_q(pulse_o), .irq_q(irq_o)
  );

  // R4: the output level moves only after an underflow, control write or start pulse
  a_r4_out_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(pulse_o) |-> ($past(uf_w) || $past(ctl_wr_w) || $past(ext_start)));

  // R5: running falls only on a stop write or a one-shot final underflow
  a_r5_halt_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(running_o) |-> ($past(ctl_wr_w) ||
                          ($past(uf_w) && $past(mode_q_w) == MODE_ONESHOT && $past(phase_w))));

  // R9: an interrupt follows a running tick taken at zero
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(count_tick) && $past(running_o) && $past(count_o) == '0));
endmodule

// File: tb/pulse_timer_bench.sv
`timescale 1ns/1ps
module pulse_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        count_tick = 1'b1;
  logic        ext_start = 1'b0;
  logic        pulse_o, irq_o, running_o;
  logic [15:0] count_o;

  always #2.5 clk = ~clk;

  pulse_timer u_pulse_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_tick(count_tick), .ext_start(ext_start),
    .pulse_o(pulse_o), .irq_o(irq_o), .running_o(running_o), .count_o(count_o)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  o;
    logic  i;
    logic  r;
    int    c;
    string req;
  } exp_t;
  exp_t sb[$];

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic push(int at, logic o, logic i, logic r, int c, string req);
    exp_t e;
    e.at = at; e.o = o; e.i = i; e.r = r; e.c = c; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations at their cycle
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      if (e.at < cyc) check(e.req, "missed slot", cyc, e.at);
      else begin
        check(e.req, "pulse_o", pulse_o, e.o);
        check(e.req, "irq_o", irq_o, e.i);
        check(e.req, "running_o", running_o, e.r);
        if (e.c >= 0) check(e.req, "count_o", count_o, e.c);
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig();
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected end before it", cyc);
    finish_run();
  end

  initial begin
    int s;
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "pulse_o", pulse_o, 0);
    check("R1", "irq_o", irq_o, 0);
    check("R1", "running_o", running_o, 0);
    check("R1", "count_o", count_o, 0);

    // one-shot C=3 R=2, irq on
    wr(2'd0, 16'd3);
    check("R2", "count_o", count_o, 3);
    @(negedge clk);
    check("R3", "count_o stopped", count_o, 3);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0005);
    s = cyc;
    check("R3", "running_o", running_o, 1);
    check("R3", "pulse_o", pulse_o, 0);
    push(s+2, 0, 0, 1, 1, "R3");
    push(s+4, 1, 1, 1, 2, "R4");
    push(s+5, 1, 0, 1, 1, "R4");
    push(s+7, 0, 1, 0, 0, "R5");
    push(s+8, 0, 0, 0, 0, "R5");
    wait_to(s+12);
    check("R5", "count_o at rest", count_o, 0);
    check("R5", "running_o", running_o, 0);

    // gated ticks, start by ext pulse, R11 ignored starts
    count_tick = 1'b0;
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'h0004);
    trig();
    check("R3", "running_o after ext start", running_o, 1);
    repeat (4) @(negedge clk);
    check("R3", "count_o without ticks", count_o, 5);
    count_tick = 1'b1;
    s = cyc;
    push(s+4, 0, 0, 1, 1, "R11");
    push(s+6, 1, 1, 1, 1, "R4");
    push(s+8, 0, 1, 0, 0, "R5");
    wait_to(s+2);
    trig();
    wr(2'd2, 16'h0005);
    wait_to(s+10);

    // R10 preset
    wr(2'd2, 16'h0008);
    check("R10", "pulse_o preset high", pulse_o, 1);
    wr(2'd2, 16'h0000);
    check("R10", "pulse_o preset low", pulse_o, 0);

    // continuous C=2 R=1, irq off
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'h0003);
    s = cyc;
    check("R6", "pulse_o at start", pulse_o, 1);
    push(s+3, 0, 0, 1, 1, "R7");
    push(s+5, 1, 0, 1, 1, "R7");
    push(s+7, 0, 0, 1, 1, "R9");
    push(s+9, 1, 0, 1, 1, "R7");
    wait_to(s+10);
    held = count_o;
    wr(2'd2, 16'h0008);
    check("R8", "running_o after stop", running_o, 0);
    check("R10", "pulse_o after stop", pulse_o, 1);
    held = count_o;
    repeat (3) @(negedge clk);
    check("R8", "count_o held", count_o, held);
    check("R8", "pulse_o held", pulse_o, 1);

    // continuous C=0 R=0, irq on: underflow every tick
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0007);
    s = cyc;
    check("R6", "pulse_o at start", pulse_o, 0);
    push(s+1, 1, 1, 1, 0, "R9");
    push(s+2, 0, 1, 1, 0, "R9");
    push(s+3, 1, 1, 1, 0, "R7");
    wait_to(s+3);
    push(s+4, 0, 0, 0, 0, "R8");
    push(s+6, 0, 0, 0, 0, "R8");
    wr(2'd2, 16'h0002);
    wait_to(s+7);

    // one-shot C=1 R=0, irq off
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0001);
    s = cyc;
    push(s+2, 1, 0, 1, 0, "R9");
    push(s+3, 0, 0, 0, 0, "R9");
    wait_to(s+6);
    check("R5", "count_o at rest", count_o, 0);
    check("R5", "pulse_o after shot", pulse_o, 0);

    @(negedge clk);
    check("R4", "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule